// File: doc/BRIEF.md
# Load-Linked Alignment and Reservation Unit

This block services load-linked requests from a processor pipeline in two sizes: a narrow word and a full-register doubleword. A request gives a virtual address, a size select and the core's debug-mode state. An external translation port returns the physical address within the same cycle. The block checks alignment first. A misaligned request raises a one-cycle address-error-on-load pulse. It may also update a bad-address register, but never while the core is in debug mode. No memory traffic follows such a request.

An aligned request leads to one read on the memory request port, addressed by the physical address that was captured when the request was accepted. When the response arrives, the unit extends the data. A word result is sign-extended to the register width and a doubleword is passed through unchanged. The unit then records a reservation made of the physical address, the virtual address and the returned value, and strobes done for one cycle. A store-conditional stage elsewhere uses that reservation. Translation, the memory and the store-conditional check sit outside the block.

Top module: `ll_reserve_unit`

## Requirements
- R1: While synchronous reset is held and just after it, req_ready is 1, and done, exc_adel, mem_req_valid and rsv_valid are 0. rsv_paddr, rsv_vaddr, rsv_value and bad_vaddr all read 0.
- R2: A word request (req_dword=0) is misaligned when req_vaddr[1:0] is non-zero. Its exc_adel pulse appears for one cycle, in the cycle after acceptance, and no memory read is issued.
- R3: A doubleword request (req_dword=1) is misaligned when req_vaddr[2:0] is non-zero. It raises exc_adel in the same way, so a word-aligned address with bit 2 set still faults.
- R4: On a misaligned request with req_debug=0, bad_vaddr takes the full faulting virtual address. With req_debug=1 it keeps its previous value. It changes at no other time.
- R5: A misaligned request produces no done strobe. It leaves rsv_valid, rsv_paddr, rsv_vaddr and rsv_value unchanged and leaves the returned result (ll_result) unchanged.
- R6: An aligned request issues exactly one memory read. The read carries the physical address sampled from xlat_paddr in the accept cycle and the request's size bit. Address and valid are held until mem_req_ready.
- R7: done pulses for exactly one cycle, in the cycle after the cycle where mem_rsp_valid is seen with a read outstanding.
- R8: For a word request, ll_result equals the low 32 bits of mem_rsp_data, sign-extended from bit 31 to 64 bits.
- R9: For a doubleword request, ll_result equals mem_rsp_data unmodified.
- R10: When done is high, rsv_valid is 1 and the reservation holds the request's physical address, its virtual address and the returned result. The reservation changes at no other time.
- R11: req_ready is 0 from the acceptance of an aligned request until done is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Load-linked request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_debug | input | 1 | Core is in debug mode |
| xlat_vaddr | output | VA_W | Address presented to the translation port |
| xlat_paddr | input | PA_W | Translated physical address (same cycle) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Physical read address |
| mem_req_dword | output | 1 | Read size, 1 = doubleword |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | XLEN | Read data |
| done | output | 1 | One-cycle completion strobe |
| ll_result | output | XLEN | Extended load-linked result |
| exc_adel | output | 1 | One-cycle address-error-on-load pulse |
| bad_vaddr | output | VA_W | Last faulting virtual address |
| rsv_valid | output | 1 | Reservation held |
| rsv_paddr | output | PA_W | Reserved physical address |
| rsv_vaddr | output | VA_W | Reserved virtual address |
| rsv_value | output | XLEN | Value loaded with the reservation |

## Verification
A wrong alignment decision shows up one cycle after acceptance. The unit either raises exc_adel where done should follow, or it issues a read with no fault. A stale or wrongly latched physical address appears on mem_req_addr as soon as the read is issued. It then reappears in rsv_paddr in the cycle that done rises. Faults in the extension or the reservation bank show in ll_result and the rsv_* outputs in that same done cycle. A bad-address update that wrongly ignores debug mode shows on bad_vaddr in the cycle after the fault.

// File: rtl/llr_pkg.sv
package llr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } llr_state_e;

   function automatic int unsigned llr_log2_bytes(input int unsigned bits);
      return $clog2(bits / 8);
   endfunction

endpackage

// File: rtl/llr_align_chk.sv
module llr_align_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned XLEN   = 64,
   localparam int unsigned W_LSB  = llr_pkg::llr_log2_bytes(WORD_W),
   localparam int unsigned DW_LSB = llr_pkg::llr_log2_bytes(XLEN)
) (
   input  logic [DW_LSB-1:0] va_low,
   input  logic              is_dword,
   output logic              misaligned
);

   logic word_bad;
   logic dword_bad;

   generate
      if (W_LSB == 0) begin : g_word_byte
         assign word_bad = 1'b0;
      end else begin : g_word_mask
         assign word_bad = |va_low[W_LSB-1:0];
      end
   endgenerate

   assign dword_bad  = |va_low;
   assign misaligned = is_dword ? dword_bad : word_bad;

endmodule

// File: rtl/llr_extend.sv
module llr_extend #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned XLEN   = 64
) (
   input  logic [XLEN-1:0] raw,
   input  logic            is_dword,
   output logic [XLEN-1:0] value
);

   localparam int unsigned EXT_W = XLEN - WORD_W;

   logic [XLEN-1:0] word_ext;

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign word_ext = raw;
      end else begin : g_sign_ext
         assign word_ext = {{EXT_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
      end
   endgenerate

   assign value = is_dword ? raw : word_ext;

endmodule

// File: rtl/llr_rsv_bank.sv
module llr_rsv_bank #(
   parameter int unsigned VA_W = 64,
   parameter int unsigned PA_W = 36,
   parameter int unsigned XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [PA_W-1:0] cap_paddr,
   input  logic [VA_W-1:0] cap_vaddr,
   input  logic [XLEN-1:0] cap_value,
   output logic            rsv_valid,
   output logic [PA_W-1:0] rsv_paddr,
   output logic [VA_W-1:0] rsv_vaddr,
   output logic [XLEN-1:0] rsv_value
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsv_valid <= 1'b0;
         rsv_paddr <= '0;
         rsv_vaddr <= '0;
         rsv_value <= '0;
      end else if (capture) begin
         rsv_valid <= 1'b1;
         rsv_paddr <= cap_paddr;
         rsv_vaddr <= cap_vaddr;
         rsv_value <= cap_value;
      end
   end

endmodule

// File: rtl/llr_ctrl.sv
module llr_ctrl
   import llr_pkg::*;
#(
   parameter int unsigned VA_W = 64,
   parameter int unsigned PA_W = 36
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_dword,
   input  logic            req_debug,
   input  logic            misaligned,
   input  logic [PA_W-1:0] xlat_paddr,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   output logic            mem_req_dword,
   input  logic            mem_rsp_valid,
   output logic            capture,
   output logic [VA_W-1:0] cap_vaddr,
   output logic            cap_dword,
   output logic            done,
   output logic            exc_adel,
   output logic [VA_W-1:0] bad_vaddr
);

   llr_state_e      state_q;
   logic [VA_W-1:0] vaddr_q;
   logic [PA_W-1:0] paddr_q;
   logic            dword_q;
   logic            done_q;
   logic            exc_q;
   logic [VA_W-1:0] badv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vaddr_q <= '0;
         paddr_q <= '0;
         dword_q <= 1'b0;
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
         badv_q  <= '0;
      end else begin
         done_q <= 1'b0;
         exc_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (misaligned) begin
                     exc_q <= 1'b1;
                     if (!req_debug) begin
                        badv_q <= req_vaddr;
                     end
                  end else begin
                     vaddr_q <= req_vaddr;
                     paddr_q <= xlat_paddr;
                     dword_q <= req_dword;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_ISSUE);
   assign mem_req_addr  = paddr_q;
   assign mem_req_dword = dword_q;
   assign capture       = (state_q == ST_WAIT) && mem_rsp_valid;
   assign cap_vaddr     = vaddr_q;
   assign cap_dword     = dword_q;
   assign done          = done_q;
   assign exc_adel      = exc_q;
   assign bad_vaddr     = badv_q;

endmodule

// File: rtl/ll_reserve_unit.sv
module ll_reserve_unit #(
   parameter int unsigned VA_W   = 64,
   parameter int unsigned PA_W   = 36,
   parameter int unsigned XLEN   = 64,
   parameter int unsigned WORD_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_dword,
   input  logic            req_debug,
   output logic [VA_W-1:0] xlat_vaddr,
   input  logic [PA_W-1:0] xlat_paddr,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   output logic            mem_req_dword,
   input  logic            mem_rsp_valid,
   input  logic [XLEN-1:0] mem_rsp_data,
   output logic            done,
   output logic [XLEN-1:0] ll_result,
   output logic            exc_adel,
   output logic [VA_W-1:0] bad_vaddr,
   output logic            rsv_valid,
   output logic [PA_W-1:0] rsv_paddr,
   output logic [VA_W-1:0] rsv_vaddr,
   output logic [XLEN-1:0] rsv_value
);

   localparam int unsigned DW_LSB = llr_pkg::llr_log2_bytes(XLEN);

   generate
      if (XLEN != 2 * WORD_W) begin : g_bad_ratio
         $error("ll_reserve_unit: XLEN must be twice WORD_W");
      end
      if ((WORD_W < 8) || ((WORD_W & (WORD_W - 1)) != 0)) begin : g_bad_word
         $error("ll_reserve_unit: WORD_W must be a power of two of at least 8");
      end
      if (VA_W < DW_LSB + 1) begin : g_bad_va
         $error("ll_reserve_unit: VA_W too narrow");
      end
   endgenerate

   logic            misaligned;
   logic            capture;
   logic [VA_W-1:0] cap_vaddr;
   logic            cap_dword;
   logic [XLEN-1:0] ext_value;

   assign xlat_vaddr = req_vaddr;

   llr_align_chk #(
      .WORD_W (WORD_W),
      .XLEN   (XLEN)
   ) u_align (
      .va_low     (req_vaddr[DW_LSB-1:0]),
      .is_dword   (req_dword),
      .misaligned (misaligned)
   );

   llr_ctrl #(
      .VA_W (VA_W),
      .PA_W (PA_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_dword     (req_dword),
      .req_debug     (req_debug),
      .misaligned    (misaligned),
      .xlat_paddr    (xlat_paddr),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_req_dword (mem_req_dword),
      .mem_rsp_valid (mem_rsp_valid),
      .capture       (capture),
      .cap_vaddr     (cap_vaddr),
      .cap_dword     (cap_dword),
      .done          (done),
      .exc_adel      (exc_adel),
      .bad_vaddr     (bad_vaddr)
   );

   llr_extend #(
      .WORD_W (WORD_W),
      .XLEN   (XLEN)
   ) u_extend (
      .raw      (mem_rsp_data),
      .is_dword (cap_dword),
      .value    (ext_value)
   );

   llr_rsv_bank #(
      .VA_W (VA_W),
      .PA_W (PA_W),
      .XLEN (XLEN)
   ) u_rsv (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .cap_paddr (mem_req_addr),
      .cap_vaddr (cap_vaddr),
      .cap_value (ext_value),
      .rsv_valid (rsv_valid),
      .rsv_paddr (rsv_paddr),
      .rsv_vaddr (rsv_vaddr),
      .rsv_value (rsv_value)
   );

   assign ll_result = rsv_value;

endmodule

// File: rtl/llr_sva.sv
module llr_sva #(
   parameter int unsigned VA_W   = 64,
   parameter int unsigned PA_W   = 36,
   parameter int unsigned XLEN   = 64,
   parameter int unsigned WORD_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            req_dword,
   input logic            req_debug,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            done,
   input logic            exc_adel,
   input logic [VA_W-1:0] bad_vaddr,
   input logic            rsv_valid,
   input logic [PA_W-1:0] rsv_paddr,
   input logic [VA_W-1:0] rsv_vaddr,
   input logic [XLEN-1:0] rsv_value
);

   localparam int unsigned W_LSB  = $clog2(WORD_W / 8);
   localparam int unsigned DW_LSB = $clog2(XLEN / 8);

   logic req_bad;
   assign req_bad = req_dword ? (req_vaddr[DW_LSB-1:0] != '0)
                              : (req_vaddr[W_LSB-1:0] != '0);

   // R2 R3
   exc_after_bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_adel |-> $past(req_valid && req_ready && req_bad));

   // R5
   exc_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_adel |-> !done);

   // R4
   badv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_adel |-> $stable(bad_vaddr));

   // R4
   badv_debug_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_adel && $past(req_debug)) |-> $stable(bad_vaddr));

   // R6
   memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R11
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R10
   rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(rsv_paddr) && $stable(rsv_vaddr) && $stable(rsv_value)));

   // R10
   rsv_set_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rsv_valid);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind ll_reserve_unit llr_sva #(
   .VA_W   (VA_W),
   .PA_W   (PA_W),
   .XLEN   (XLEN),
   .WORD_W (WORD_W)
) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_vaddr     (req_vaddr),
   .req_dword     (req_dword),
   .req_debug     (req_debug),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .exc_adel      (exc_adel),
   .bad_vaddr     (bad_vaddr),
   .rsv_valid     (rsv_valid),
   .rsv_paddr     (rsv_paddr),
   .rsv_vaddr     (rsv_vaddr),
   .rsv_value     (rsv_value)
);

// File: tb/ll_reserve_unit_tb.sv
module ll_reserve_unit_tb;

   localparam int unsigned VA_W = 64;
   localparam int unsigned PA_W = 36;
   localparam int unsigned XLEN = 64;
   localparam logic [PA_W-1:0] PA_SALT = 36'h9_0F00_D000;

   typedef struct {
      bit              is_exc;
      logic [XLEN-1:0] result;
      logic [PA_W-1:0] paddr;
      logic [VA_W-1:0] vaddr;
      logic [VA_W-1:0] badv;
      bit              rvld;
      bit              dword;
      int              reads;
      string           tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [VA_W-1:0] req_vaddr = '0;
   logic            req_dword = 1'b0;
   logic            req_debug = 1'b0;
   logic [VA_W-1:0] xlat_vaddr;
   logic [PA_W-1:0] xlat_paddr;
   logic            mem_req_valid;
   logic            mem_req_ready = 1'b0;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_req_dword;
   logic            mem_rsp_valid = 1'b0;
   logic [XLEN-1:0] mem_rsp_data = '0;
   logic            done;
   logic [XLEN-1:0] ll_result;
   logic            exc_adel;
   logic [VA_W-1:0] bad_vaddr;
   logic            rsv_valid;
   logic [PA_W-1:0] rsv_paddr;
   logic [VA_W-1:0] rsv_vaddr;
   logic [XLEN-1:0] rsv_value;

   int errors = 0;
   int checks = 0;
   int reads  = 0;
   logic [PA_W-1:0] last_addr = '0;
   logic            last_dword = 1'b0;

   exp_t            sb[$];
   logic [XLEN-1:0] mem_q[$];

   logic [PA_W-1:0] m_pa = '0;
   logic [VA_W-1:0] m_va = '0;
   logic [XLEN-1:0] m_val = '0;
   logic [VA_W-1:0] m_badv = '0;
   bit              m_rvld = 1'b0;
   int              m_reads = 0;

   always #10 clk = ~clk;

   assign xlat_paddr = xlat_vaddr[PA_W-1:0] ^ PA_SALT;

   ll_reserve_unit u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_dword     (req_dword),
      .req_debug     (req_debug),
      .xlat_vaddr    (xlat_vaddr),
      .xlat_paddr    (xlat_paddr),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_req_dword (mem_req_dword),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done          (done),
      .ll_result     (ll_result),
      .exc_adel      (exc_adel),
      .bad_vaddr     (bad_vaddr),
      .rsv_valid     (rsv_valid),
      .rsv_paddr     (rsv_paddr),
      .rsv_vaddr     (rsv_vaddr),
      .rsv_value     (rsv_value)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Memory stub: ready toggles, response three negedges after the handshake.
   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = (mem_q.size() > 0) ? mem_q.pop_front() : '0;
            end
         end
         mem_req_ready = ~mem_req_ready;
         if (mem_req_valid && mem_req_ready && rst_n) begin
            reads++;
            last_addr  = mem_req_addr;
            last_dword = mem_req_dword;
            cnt = 3;
         end
      end
   end

   // Monitor: pops scoreboard on each exception or done pulse.
   initial begin
      bit prev_ev;
      prev_ev = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && (done || exc_adel)) begin
            chk(!prev_ev, "R7", "pulse longer than one cycle", 64'(done), 64'd0);
            if (sb.size() == 0) begin
               chk(1'b0, "R5", "unexpected event", 64'(done), 64'(exc_adel));
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(exc_adel == e.is_exc, e.is_exc ? "R2" : "R7",
                   {e.tag, " exc_adel"}, 64'(exc_adel), 64'(e.is_exc));
               chk(done == !e.is_exc, e.is_exc ? "R5" : "R7",
                   {e.tag, " done"}, 64'(done), 64'(!e.is_exc));
               chk(bad_vaddr == e.badv, "R4", {e.tag, " bad_vaddr"}, bad_vaddr, e.badv);
               chk(ll_result == e.result, e.is_exc ? "R5" : (e.dword ? "R9" : "R8"),
                   {e.tag, " ll_result"}, ll_result, e.result);
               chk(rsv_paddr == e.paddr, "R10", {e.tag, " rsv_paddr"},
                   64'(rsv_paddr), 64'(e.paddr));
               chk(rsv_vaddr == e.vaddr, "R10", {e.tag, " rsv_vaddr"}, rsv_vaddr, e.vaddr);
               chk(rsv_value == e.result, "R10", {e.tag, " rsv_value"}, rsv_value, e.result);
               chk(rsv_valid == e.rvld, "R10", {e.tag, " rsv_valid"},
                   64'(rsv_valid), 64'(e.rvld));
               chk(reads == e.reads, "R6", {e.tag, " read count"},
                   64'(reads), 64'(e.reads));
               if (!e.is_exc) begin
                  chk(last_addr == e.paddr, "R6", {e.tag, " read address"},
                      64'(last_addr), 64'(e.paddr));
                  chk(last_dword == e.dword, "R6", {e.tag, " read size"},
                      64'(last_dword), 64'(e.dword));
                  chk(req_ready == 1'b1, "R11", {e.tag, " ready after done"},
                      64'(req_ready), 64'd1);
               end
            end
            prev_ev = 1'b1;
         end else begin
            prev_ev = 1'b0;
         end
      end
   end

   task automatic do_ll(input logic [VA_W-1:0] va, input bit dw, input bit dbg,
                        input logic [XLEN-1:0] data, input string tag);
      exp_t e;
      bit bad;
      bad = dw ? (va[2:0] != 3'd0) : (va[1:0] != 2'd0);
      e.tag = tag;
      e.is_exc = bad;
      e.dword = dw;
      if (bad) begin
         if (!dbg) m_badv = va;
      end else begin
         m_pa = va[PA_W-1:0] ^ PA_SALT;
         m_va = va;
         m_val = dw ? data : {{32{data[31]}}, data[31:0]};
         m_rvld = 1'b1;
         m_reads++;
         mem_q.push_back(data);
      end
      e.result = m_val;
      e.paddr = m_pa;
      e.vaddr = m_va;
      e.badv = m_badv;
      e.rvld = m_rvld;
      e.reads = m_reads;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_dword = dw;
      req_debug = dbg;
      @(negedge clk);
      req_valid = 1'b0;
      if (!bad) begin
         chk(req_ready == 1'b0, "R11", {tag, " ready while busy"}, 64'(req_ready), 64'd0);
      end
      wait (sb.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      chk(1'b0, "R1", "watchdog expired", 64'(cyc), 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
      chk(!done && !exc_adel && !mem_req_valid, "R1", "strobes",
          {61'd0, done, exc_adel, mem_req_valid}, 64'd0);
      chk(rsv_valid == 1'b0, "R1", "rsv_valid", 64'(rsv_valid), 64'd0);
      chk(rsv_value == '0 && bad_vaddr == '0, "R1", "regs", rsv_value | bad_vaddr, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      do_ll(64'h0000_0040_0000_1000, 1'b0, 1'b0, 64'h1234_5678_8765_4321, "R8 word neg");
      do_ll(64'h0000_0040_0000_2004, 1'b0, 1'b0, 64'hDEAD_BEEF_1234_5678, "R8 word pos");
      do_ll(64'h0000_0040_0000_3008, 1'b1, 1'b0, 64'h8000_0001_FFFF_0000, "R9 dword");
      do_ll(64'hFFFF_FFFF_8000_0001, 1'b0, 1'b0, 64'd0, "R2 word off1");
      do_ll(64'h0000_0000_1234_5672, 1'b0, 1'b1, 64'd0, "R4 word debug");
      do_ll(64'h0000_0055_0000_0104, 1'b1, 1'b0, 64'd0, "R3 dword off4");
      do_ll(64'h0000_0055_0000_0203, 1'b0, 1'b0, 64'd0, "R2 word off3");
      do_ll(64'h0000_0077_0000_0301, 1'b1, 1'b1, 64'd0, "R3 dword debug");
      do_ll(64'h0000_0066_0000_4010, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, "R9 dword pos");
      do_ll(64'h0000_0066_0000_500C, 1'b0, 1'b1, 64'hFFFF_FFFF_7FFF_FFFF, "R8 word debug ok");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule